// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the clock and data lines of an I2C bus and detects the two bus conditions that frame every transfer. A START is a falling data line while the clock stays high. A STOP is a rising data line while the clock stays high. Both lines are first brought into the local clock domain by a synchroniser. The block keeps two sticky status bits, one for the most recent START and one for the most recent STOP. From these bits it reports whether the bus is free for a new master to claim.

A single interrupt flag collects three kinds of event: a START, a STOP, and a byte-completion strobe from an external shift register. The flag holds until software clears it with a one-cycle pulse. A master that is waiting for the bus can clear the flag and wait for it to rise again, because the STOP that ends another master's transfer raises it. Pulling the enable input low clears the status bits and blocks all events.

Top module: `i2c_bus_monitor`

## Requirements
- R1: While rst_n is low at a clock edge, start_seen, stop_seen and irq_flag all become 0 and bus_free becomes 1.
- R2: A START (sda_in going 1 to 0 while scl_in is 1 both before and after) sets start_seen and clears stop_seen. The outputs change on the third rising clock edge after the line change, and not before.
- R3: A STOP (sda_in going 0 to 1 while scl_in is 1 both before and after) sets stop_seen and clears start_seen, with the same three-edge latency as R2.
- R4: bus_free is 1 when stop_seen is 1 or when both status bits are 0. Otherwise it is 0.
- R5: Any sda_in change while scl_in is 0, or in the same sample as a change of scl_in, leaves start_seen, stop_seen and irq_flag unchanged.
- R6: A START or STOP sets irq_flag on the same edge that updates the status bits.
- R7: A one-cycle byte_done pulse while enabled sets irq_flag on the next rising edge.
- R8: irq_flag stays set until an irq_clr pulse clears it on the next edge. If an event is detected on the same edge, the event wins and the flag stays set.
- R9: While enable is 0, start_seen and stop_seen are cleared on the next edge, and neither bus conditions nor byte_done set irq_flag. A flag that is already set keeps its value.
- R10: start_seen and stop_seen are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Module enable; when low, clears the status bits and blocks events |
| scl_in | input | 1 | Bus clock line, asynchronous to clk |
| sda_in | input | 1 | Bus data line, asynchronous to clk |
| byte_done | input | 1 | Byte-completion strobe from the external shifter |
| irq_clr | input | 1 | One-cycle software clear for the interrupt flag |
| start_seen | output | 1 | Set by the most recent START |
| stop_seen | output | 1 | Set by the most recent STOP |
| bus_free | output | 1 | The bus may be claimed |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Line changes pass through two synchroniser flops and one status register, so a bus condition is expected on the third rising edge after the bench drives the lines. The bench drives on falling edges. It checks the old values two falling edges later and the new values three falling edges later, which pins the latency exactly. The byte strobe, the flag clear and the enable drop act through a single register, so their results are sampled at the first falling edge after the stimulus. The sweep steps through every pair of old and new line states, both enabled and disabled, and a reference model in the bench derives the expected bits for each transition.

// File: rtl/i2c_mon_pkg.sv
// Package: types and constants shared by the bus condition monitor.
// Assumes: two bus lines, ordered clock first, data second, in the packed line vector.
package i2c_mon_pkg;

    localparam int unsigned LINE_COUNT = 2;
    localparam int unsigned LINE_SCL   = 0;
    localparam int unsigned LINE_SDA   = 1;

    // One cycle of detected bus conditions.
    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

endpackage

// File: rtl/i2c_mon_sync.sv
// Module: i2c_mon_sync
// Brings each asynchronous bus line into the clk domain through a chain of flops.
// Assumes: STAGES >= 2. Lines idle high on the bus, so the chain resets to all ones.
module i2c_mon_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_async,
    output logic [LINES-1:0] line_sync
);

    localparam int unsigned TOP = STAGES - 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw line level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], line_async[g]};
            end
        end

        assign line_sync[g] = chain[TOP];
    end

endmodule

// File: rtl/i2c_mon_cond_det.sv
// Module: i2c_mon_cond_det
// Compares the synchronised lines with their previous sample and flags START/STOP.
// Assumes: inputs are already synchronous. A condition requires the clock line high
// in both samples, so a data change that coincides with a clock change is not a condition.
module i2c_mon_cond_det
    import i2c_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      scl_s,
    input  logic      sda_s,
    output bus_cond_t cond
);

    logic scl_prev;
    logic sda_prev;
    logic scl_held_high;

    // Keep the previous sample of both lines; tracking runs even while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Classify the data-line edge seen with the clock line high.
    always_comb begin
        scl_held_high = scl_prev & scl_s;
        cond.start    = enable & scl_held_high & sda_prev & ~sda_s;
        cond.stop     = enable & scl_held_high & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_mon_status.sv
// Module: i2c_mon_status
// Holds the last-START and last-STOP bits and derives the bus-free indication.
// Assumes: START and STOP are never flagged in the same cycle.
module i2c_mon_status
    import i2c_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  bus_cond_t cond,
    output logic      start_bit,
    output logic      stop_bit,
    output logic      free
);

    // Record the most recent condition; disable or reset wipes both bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            start_bit <= 1'b0;
            stop_bit  <= 1'b0;
        end else if (cond.start) begin
            start_bit <= 1'b1;
            stop_bit  <= 1'b0;
        end else if (cond.stop) begin
            start_bit <= 1'b0;
            stop_bit  <= 1'b1;
        end
    end

    // The bus is free after a STOP or when no condition has been seen yet.
    always_comb begin
        free = stop_bit | (~start_bit & ~stop_bit);
    end

endmodule

// File: rtl/i2c_mon_irq.sv
// Module: i2c_mon_irq
// Sticky interrupt flag fed by bus conditions and byte completion.
// Assumes: clear is a one-cycle pulse; an event in the same cycle takes priority.
module i2c_mon_irq
    import i2c_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  bus_cond_t cond,
    input  logic      byte_strobe,
    input  logic      clear,
    output logic      flag
);

    logic event_hit;

    // Merge all event sources; byte completion counts only while enabled.
    always_comb begin
        event_hit = cond.start | cond.stop | (enable & byte_strobe);
    end

    // Set on any event, drop on clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (event_hit) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_bus_monitor.sv
// Module: i2c_bus_monitor (top)
// Watches the I2C lines, keeps START/STOP status, reports a free bus and
// raises a sticky interrupt flag. Synchronous active-low reset.
// Assumes: scl_in/sda_in are asynchronous; byte_done and irq_clr are clk-synchronous pulses.
module i2c_bus_monitor
    import i2c_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic byte_done,
    input  logic irq_clr,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq_flag
);

    logic [LINE_COUNT-1:0] lines_raw;
    logic [LINE_COUNT-1:0] lines_sync;
    bus_cond_t             cond;

    // Pack the bus lines in package order.
    always_comb begin
        lines_raw           = '0;
        lines_raw[LINE_SCL] = scl_in;
        lines_raw[LINE_SDA] = sda_in;
    end

    i2c_mon_sync #(
        .LINES  (LINE_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (lines_raw),
        .line_sync  (lines_sync)
    );

    i2c_mon_cond_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .scl_s  (lines_sync[LINE_SCL]),
        .sda_s  (lines_sync[LINE_SDA]),
        .cond   (cond)
    );

    i2c_mon_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cond      (cond),
        .start_bit (start_seen),
        .stop_bit  (stop_seen),
        .free      (bus_free)
    );

    i2c_mon_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cond        (cond),
        .byte_strobe (byte_done),
        .clear       (irq_clr),
        .flag        (irq_flag)
    );

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
// Module: i2c_bus_monitor_chk
// Property checker bound to the top module; observes its ports only.
module i2c_bus_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic sda_in,
    input logic byte_done,
    input logic irq_clr,
    input logic start_seen,
    input logic stop_seen,
    input logic bus_free,
    input logic irq_flag
);

    // Status bits are mutually exclusive (R10).
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    // A seen START means the bus is taken (R4).
    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |-> !bus_free);

    // A seen STOP means the bus is free (R4).
    p_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |-> bus_free);

    // Condition status bits rise together with the flag (R6).
    p_start_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_seen) |-> irq_flag);

    p_stop_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> irq_flag);

    // Byte completion while enabled sets the flag (R7).
    p_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && byte_done) |=> irq_flag);

    // Without a clear the flag never drops (R8).
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // Disabling wipes the status bits on the next edge (R9).
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_seen && !stop_seen));

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (.*);

// File: tb/tb_i2c_bus_monitor.sv
`timescale 1ns/1ps
module tb_i2c_bus_monitor;

    logic clk = 1'b0;
    logic rst_n, enable, scl_in, sda_in, byte_done, irq_clr;
    logic start_seen, stop_seen, bus_free, irq_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Reference model state
    bit m_start, m_stop, m_flag, cur_scl, cur_sda;

    always #4 clk = ~clk;

    i2c_bus_monitor dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
        .byte_done(byte_done), .irq_clr(irq_clr), .start_seen(start_seen),
        .stop_seen(stop_seen), .bus_free(bus_free), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "start_seen", start_seen, m_start);
        chk(req, "stop_seen",  stop_seen,  m_stop);
        chk("R4", "bus_free",  bus_free,   m_stop || (!m_start && !m_stop));
        chk(req, "irq_flag",   irq_flag,   m_flag);
    endtask

    // Drive new line levels and check old values at 2 edges and new values at 3 edges.
    task automatic move_lines(input bit s, input bit d, input string req);
        bit ev_start, ev_stop;
        ev_start = enable && cur_scl && s && cur_sda && !d;
        ev_stop  = enable && cur_scl && s && !cur_sda && d;
        @(negedge clk);
        scl_in = s; sda_in = d;
        repeat (2) @(negedge clk);
        chk_all({req, " (latency, before)"});
        if (ev_start) begin m_start = 1; m_stop = 0; m_flag = 1; end
        if (ev_stop)  begin m_start = 0; m_stop = 1; m_flag = 1; end
        cur_scl = s; cur_sda = d;
        @(negedge clk);
        chk_all(ev_start ? "R2" : ev_stop ? "R3" : "R5");
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        m_flag = 0;
        chk("R8", "irq_flag after clear", irq_flag, 1'b0);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                move_lines(a[1], a[0], tag);
                pulse_clear();
                move_lines(b[1], b[0], tag);
            end
        end
    endtask

    initial begin
        rst_n = 0; enable = 1; scl_in = 1; sda_in = 1; byte_done = 0; irq_clr = 0;
        cur_scl = 1; cur_sda = 1; m_start = 0; m_stop = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_all("R1");
        rst_n = 1;
        @(negedge clk);
        chk_all("R1");

        // R2/R3/R5/R6: every old/new line pair, enabled
        sweep("R6");

        // R7: byte strobe sets flag after one edge
        pulse_clear();
        @(negedge clk); byte_done = 1;
        @(negedge clk); byte_done = 0; m_flag = 1;
        chk("R7", "irq_flag after byte_done", irq_flag, 1'b1);

        // R8: sticky for several cycles
        repeat (10) @(negedge clk);
        chk("R8", "irq_flag sticky", irq_flag, 1'b1);

        // R8: event wins over clear in same cycle
        @(negedge clk); byte_done = 1; irq_clr = 1;
        @(negedge clk); byte_done = 0; irq_clr = 0;
        chk("R8", "event beats clear", irq_flag, 1'b1);
        pulse_clear();

        // R9: START then disable clears status
        move_lines(1, 1, "R9");
        move_lines(1, 0, "R2");
        pulse_clear();
        @(negedge clk); enable = 0;
        @(negedge clk);
        m_start = 0; m_stop = 0;
        chk_all("R9");
        @(negedge clk); byte_done = 1;
        @(negedge clk); byte_done = 0;
        chk("R9", "byte_done ignored when disabled", irq_flag, 1'b0);
        sweep("R9");

        // Re-enable, run a full START/STOP frame
        @(negedge clk); enable = 1;
        move_lines(1, 1, "R3");
        move_lines(1, 0, "R2");
        pulse_clear();
        move_lines(0, 0, "R5");
        move_lines(0, 1, "R5");
        move_lines(0, 0, "R5");
        move_lines(1, 0, "R5");
        move_lines(1, 1, "R3");

        // R1: mid-run reset
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        m_start = 0; m_stop = 0; m_flag = 0;
        chk_all("R1");
        rst_n = 1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule